// File: doc/BRIEF.md
# Multi-channel timer compare unit

This block generates up to six pulse-width-modulated outputs from two free-running up-counters. Each counter starts from its own programmable reload value, counts up to all-ones and then wraps back to the reload value. The span between the reload value and all-ones sets the period. Each compare channel chooses one of the two counters as its time base, so one group of outputs can run at one period and the rest at another.

Software never writes a channel's live compare value directly. It writes a shadow copy, and the copy moves into the active compare register in one of two ways: when software asks for it, or when the channel's chosen counter wraps. A wrap-time transfer changes duty cycles without glitches. A channel works in one of two modes. In edge mode the output is asserted on a match and released on a wrap, with the asserted level set per channel group. In set mode software decides which level the next match applies. Software can force the second counter to wrap at once, which restarts it from its reload value and triggers its wrap-time transfers.

A flat register interface with one write port and one combinational read port gives access to all of this. Each channel also has a sticky match flag that is cleared by writing one to it.

Top module: `tmr_cmp_unit`

## Requirements
- R1: Each of the two counters adds one per clock while its run bit is set (CTRL address 0, bit 0 for timer 0, bit 1 for timer 1). From all-ones it reloads the value held at address 1 (timer 0) or address 2 (timer 1). When stopped it holds its value. The count can be read and written at address 3 (timer 0) and address 4 (timer 1).
- R2: Bit i of the select register at address 5 chooses the time base of channel i: 0 selects timer 0 and 1 selects timer 1. A channel reacts only to the counter it has selected.
- R3: Writing the shadow register of channel i (address 16+i) leaves its active compare value (read at address 24+i) unchanged. Writing 1 to bit i at address 8 copies that shadow into the active value on the same clock edge. Address 8 always reads 0.
- R4: When the counter selected by channel i wraps, the shadow of channel i is copied into its active value on the wrap edge. The match check in the first cycle after the wrap already uses the new value.
- R5: In edge mode (bit i of address 6 is 0), the output takes its asserted level one cycle after the count equals the active value. It returns to the released level one cycle after a wrap, unless the post-wrap count also matches. Over each period the output is asserted for (all-ones − compare + 1) cycles. A compare value equal to the reload value gives 100% duty, and a compare value below the reload value gives 0%.
- R6: CTRL bit 2 sets the asserted level for channels 0 to GRP_A_N−1. CTRL bit 3 sets it for the remaining channels. The released level is the inverse of the asserted level.
- R7: In set mode (bit i of address 6 is 1), a match drives output i to bit i of address 7. A wrap does not change the output.
- R8: Writing CTRL with bit 4 set forces timer 1 to wrap in that edge, whether it is running or not. Timer 1 loads its reload value and the channels on timer 1 perform their wrap-time transfer. Bit 4 reads back as 0, and timer 0 channels are unaffected.
- R9: A match sets bit i of the flag register at address 9. Writing 1 to a bit clears it, and a match in the same cycle wins over the clear. A stopped counter produces no matches.
- R10: After reset all outputs are 0. CTRL reads 0x0C: both counters are stopped and both groups assert high. All other registers and counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| cmp_out | output | N_CH | Compare outputs, one per channel |

## Verification
The bench sweeps the compare value through and around each counter's period on two channels that use different time bases. At the bottom of the sweep, a design that compares with "greater or equal" instead of an exact match would leave the output asserted for compare values below the reload value, and one that lets the wrap win over a same-cycle match would never reach 100% duty. The bench checks shadow behaviour: a design that writes the active register directly, or that transfers on the wrong counter's wrap, shows the wrong active value when read back before and after a wrap. It also checks the forced wrap, which must restart only timer 1 and must read back as zero, and set mode, where a design that releases the output on a wrap loses the software-chosen level.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
   localparam int REG_AW = 5;
   localparam int N_TMR  = 2;

   localparam logic [REG_AW-1:0] ADR_CTRL = 5'd0;
   localparam logic [REG_AW-1:0] ADR_RLD0 = 5'd1;
   localparam logic [REG_AW-1:0] ADR_RLD1 = 5'd2;
   localparam logic [REG_AW-1:0] ADR_CNT0 = 5'd3;
   localparam logic [REG_AW-1:0] ADR_CNT1 = 5'd4;
   localparam logic [REG_AW-1:0] ADR_TSEL = 5'd5;
   localparam logic [REG_AW-1:0] ADR_MODE = 5'd6;
   localparam logic [REG_AW-1:0] ADR_LVL  = 5'd7;
   localparam logic [REG_AW-1:0] ADR_XFER = 5'd8;
   localparam logic [REG_AW-1:0] ADR_FLAG = 5'd9;
   localparam logic [REG_AW-1:0] ADR_SHB  = 5'd16;
   localparam logic [REG_AW-1:0] ADR_ACTB = 5'd24;

   localparam int CTL_FRC1 = 4;

   // control word, bit 0 = run0 .. bit 3 = pol_b
   typedef struct packed {
      logic pol_b;
      logic pol_a;
      logic run1;
      logic run0;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = ctrl_t'(4'b1100);

   typedef enum logic {
      MODE_EDGE = 1'b0,
      MODE_SET  = 1'b1
   } cmp_mode_e;
endpackage

// File: rtl/tmr_cmp_counter.sv
module tmr_cmp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             frc,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap_now,
   output logic             tick_q,
   output logic             wrap_q
);
   logic at_top;

   assign at_top   = (cnt_q == {CNT_W{1'b1}});
   // a direct load of the count suppresses any wrap in the same edge
   assign wrap_now = !ld && (frc || (run && at_top));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
         wrap_q <= 1'b0;
      end else begin
         tick_q <= !ld && (run || frc);
         wrap_q <= wrap_now;
         if (ld)
            cnt_q <= ld_val;
         else if (wrap_now)
            cnt_q <= reload;
         else if (run)
            cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
   import tmr_cmp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             tick,
   input  logic             wrap_now,
   input  logic             wrap_q,
   input  logic             sw_xfer,
   input  logic             sh_we,
   input  logic [CNT_W-1:0] sh_wdata,
   input  cmp_mode_e        mode,
   input  logic             m1_lvl,
   input  logic             act_lvl,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] sh_q,
   output logic [CNT_W-1:0] act_q,
   output logic             match,
   output logic             out_q,
   output logic             flag_q
);
   // only a freshly advanced count can match
   assign match = tick && (cnt == act_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         act_q <= '0;
      end else begin
         if (sh_we)
            sh_q <= sh_wdata;
         if (sw_xfer || wrap_now)
            act_q <= sh_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else begin
         case (mode)
            MODE_SET: begin
               if (match)
                  out_q <= m1_lvl;
            end
            default: begin
               if (match)
                  out_q <= act_lvl;
               else if (wrap_q)
                  out_q <= !act_lvl;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (match)
         flag_q <= 1'b1;
      else if (flag_clr)
         flag_q <= 1'b0;
   end
endmodule

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs
   import tmr_cmp_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int N_CH  = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [REG_AW-1:0]                 wr_addr,
   input  logic [CNT_W-1:0]                  wr_data,
   input  logic [REG_AW-1:0]                 rd_addr,
   output logic [CNT_W-1:0]                  rd_data,
   input  logic [N_TMR-1:0][CNT_W-1:0]       cnt_in,
   input  logic [N_CH-1:0][CNT_W-1:0]        sh_in,
   input  logic [N_CH-1:0][CNT_W-1:0]        act_in,
   input  logic [N_CH-1:0]                   flag_in,
   output ctrl_t                             ctrl_q,
   output logic [N_TMR-1:0][CNT_W-1:0]       rld_q,
   output logic [N_TMR-1:0]                  cnt_ld,
   output logic                              frc1,
   output logic [N_CH-1:0]                   tsel_q,
   output logic [N_CH-1:0]                   mode_q,
   output logic [N_CH-1:0]                   lvl_q,
   output logic [N_CH-1:0]                   xfer,
   output logic [N_CH-1:0]                   sh_we,
   output logic [N_CH-1:0]                   flag_clr
);
   logic hit_ctrl, hit_xfer, hit_flag;

   assign hit_ctrl  = wr_en && (wr_addr == ADR_CTRL);
   assign hit_xfer  = wr_en && (wr_addr == ADR_XFER);
   assign hit_flag  = wr_en && (wr_addr == ADR_FLAG);
   assign frc1      = hit_ctrl && wr_data[CTL_FRC1];
   assign cnt_ld[0] = wr_en && (wr_addr == ADR_CNT0);
   assign cnt_ld[1] = wr_en && (wr_addr == ADR_CNT1);
   assign xfer      = hit_xfer ? wr_data[N_CH-1:0] : '0;
   assign flag_clr  = hit_flag ? wr_data[N_CH-1:0] : '0;

   for (genvar i = 0; i < N_CH; i++) begin : g_shw
      assign sh_we[i] = wr_en && (wr_addr == (ADR_SHB + REG_AW'(i)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         rld_q  <= '0;
         tsel_q <= '0;
         mode_q <= '0;
         lvl_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_CTRL: ctrl_q   <= ctrl_t'(wr_data[3:0]);
            ADR_RLD0: rld_q[0] <= wr_data;
            ADR_RLD1: rld_q[1] <= wr_data;
            ADR_TSEL: tsel_q   <= wr_data[N_CH-1:0];
            ADR_MODE: mode_q   <= wr_data[N_CH-1:0];
            ADR_LVL:  lvl_q    <= wr_data[N_CH-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADR_CTRL: rd_data[3:0]      = ctrl_q;
         ADR_RLD0: rd_data           = rld_q[0];
         ADR_RLD1: rd_data           = rld_q[1];
         ADR_CNT0: rd_data           = cnt_in[0];
         ADR_CNT1: rd_data           = cnt_in[1];
         ADR_TSEL: rd_data[N_CH-1:0] = tsel_q;
         ADR_MODE: rd_data[N_CH-1:0] = mode_q;
         ADR_LVL:  rd_data[N_CH-1:0] = lvl_q;
         ADR_FLAG: rd_data[N_CH-1:0] = flag_in;
         default: begin
            for (int i = 0; i < N_CH; i++) begin
               if (rd_addr == (ADR_SHB + REG_AW'(i)))
                  rd_data = sh_in[i];
               if (rd_addr == (ADR_ACTB + REG_AW'(i)))
                  rd_data = act_in[i];
            end
         end
      endcase
   end
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
   import tmr_cmp_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int N_CH    = 6,
   parameter int GRP_A_N = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic [N_CH-1:0]   cmp_out
);
   if (N_CH < 1 || N_CH > 8) begin : g_bad_nch
      $error("tmr_cmp_unit: N_CH must lie in 1..8");
   end
   if (CNT_W < 8 || CNT_W < N_CH) begin : g_bad_w
      $error("tmr_cmp_unit: CNT_W must be at least 8 and at least N_CH");
   end
   if (GRP_A_N < 0 || GRP_A_N > N_CH) begin : g_bad_grp
      $error("tmr_cmp_unit: GRP_A_N must lie in 0..N_CH");
   end

   ctrl_t                        ctrl;
   logic [N_TMR-1:0][CNT_W-1:0]  rld, cnt_v;
   logic [N_TMR-1:0]             cnt_ld, run_v, frc_v, wrapn_v, tick_v, wrapq_v;
   logic                         frc1;
   logic [N_CH-1:0]              tsel_v, mode_v, m1_v, xfer_v, shwe_v, fclr_v;
   logic [N_CH-1:0]              wrap_sel, wrapq_sel, tick_sel, match_v, flag_v, lvl_v;
   logic [N_CH-1:0][CNT_W-1:0]   act_v, sh_v, cnt_sel;

   tmr_cmp_regs #(.CNT_W(CNT_W), .N_CH(N_CH)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .cnt_in   (cnt_v),
      .sh_in    (sh_v),
      .act_in   (act_v),
      .flag_in  (flag_v),
      .ctrl_q   (ctrl),
      .rld_q    (rld),
      .cnt_ld   (cnt_ld),
      .frc1     (frc1),
      .tsel_q   (tsel_v),
      .mode_q   (mode_v),
      .lvl_q    (m1_v),
      .xfer     (xfer_v),
      .sh_we    (shwe_v),
      .flag_clr (fclr_v)
   );

   assign run_v = {ctrl.run1, ctrl.run0};
   assign frc_v = {frc1, 1'b0};

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      tmr_cmp_counter #(.CNT_W(CNT_W)) cnt_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run_v[t]),
         .frc      (frc_v[t]),
         .ld       (cnt_ld[t]),
         .ld_val   (wr_data),
         .reload   (rld[t]),
         .cnt_q    (cnt_v[t]),
         .wrap_now (wrapn_v[t]),
         .tick_q   (tick_v[t]),
         .wrap_q   (wrapq_v[t])
      );
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      if (i < GRP_A_N) begin : g_grp_a
         assign lvl_v[i] = ctrl.pol_a;
      end else begin : g_grp_b
         assign lvl_v[i] = ctrl.pol_b;
      end

      assign cnt_sel[i]   = cnt_v[tsel_v[i]];
      assign tick_sel[i]  = tick_v[tsel_v[i]];
      assign wrap_sel[i]  = wrapn_v[tsel_v[i]];
      assign wrapq_sel[i] = wrapq_v[tsel_v[i]];

      tmr_cmp_chan #(.CNT_W(CNT_W)) chan_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt      (cnt_sel[i]),
         .tick     (tick_sel[i]),
         .wrap_now (wrap_sel[i]),
         .wrap_q   (wrapq_sel[i]),
         .sw_xfer  (xfer_v[i]),
         .sh_we    (shwe_v[i]),
         .sh_wdata (wr_data),
         .mode     (cmp_mode_e'(mode_v[i])),
         .m1_lvl   (m1_v[i]),
         .act_lvl  (lvl_v[i]),
         .flag_clr (fclr_v[i]),
         .sh_q     (sh_v[i]),
         .act_q    (act_v[i]),
         .match    (match_v[i]),
         .out_q    (cmp_out[i]),
         .flag_q   (flag_v[i])
      );
   end
endmodule

// File: rtl/tmr_cmp_unit_chk.sv
module tmr_cmp_unit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run0,
   input logic             cnt0_ld,
   input logic [CNT_W-1:0] cnt0,
   input logic [CNT_W-1:0] rld0,
   input logic             xfer0,
   input logic             wrap0,
   input logic             wrapq0,
   input logic             match0,
   input logic             chmode0,
   input logic             lvl0,
   input logic             pol_a,
   input logic [CNT_W-1:0] act0,
   input logic [CNT_W-1:0] sh0,
   input logic             flag0,
   input logic             out0
);
   assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run0 && !cnt0_ld && cnt0 != {CNT_W{1'b1}}) |=> cnt0 == $past(cnt0) + 1'b1);

   assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run0 && !cnt0_ld && cnt0 == {CNT_W{1'b1}}) |=> cnt0 == $past(rld0));

   assert_act_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer0 && !wrap0) |=> $stable(act0));

   assert_act_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap0 |=> act0 == $past(sh0));

   assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!match0 && !wrapq0) |=> $stable(out0));

   assert_edge_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!chmode0 && wrapq0 && !match0) |=> out0 == !$past(pol_a));

   assert_set_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chmode0 && match0) |=> out0 == $past(lvl0));

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      match0 |=> flag0);
endmodule

bind tmr_cmp_unit tmr_cmp_unit_chk #(.CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .run0    (run_v[0]),
   .cnt0_ld (cnt_ld[0]),
   .cnt0    (cnt_v[0]),
   .rld0    (rld[0]),
   .xfer0   (xfer_v[0]),
   .wrap0   (wrap_sel[0]),
   .wrapq0  (wrapq_sel[0]),
   .match0  (match_v[0]),
   .chmode0 (mode_v[0]),
   .lvl0    (m1_v[0]),
   .pol_a   (ctrl.pol_a),
   .act0    (act_v[0]),
   .sh0     (sh_v[0]),
   .flag0   (flag_v[0]),
   .out0    (cmp_out[0])
);

// File: tb/tmr_cmp_unit_tb_top.sv
module tmr_cmp_unit_tb_top;
   localparam int W  = 16;
   localparam int NC = 6;

   localparam logic [4:0] A_CTRL = 5'd0, A_RLD0 = 5'd1, A_RLD1 = 5'd2, A_CNT0 = 5'd3,
                          A_CNT1 = 5'd4, A_TSEL = 5'd5, A_MODE = 5'd6, A_LVL = 5'd7,
                          A_XFER = 5'd8, A_FLAG = 5'd9, A_SH = 5'd16, A_ACT = 5'd24;
   localparam int P0 = 16'hFFF0;
   localparam int P1 = 16'hFFF8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [4:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [4:0]    rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic [NC-1:0] cmp_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   tmr_cmp_unit dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .cmp_out (cmp_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output int d);
      rd_addr = a;
      #1;
      d = int'(rd_data);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_hi(input int ch, output int n);
      n = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (cmp_out[ch]) n++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end

   initial begin
      int v, h0, h3, e0, e3;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check("R10 outputs", int'(cmp_out), 0);
      rd(A_CTRL, v); check("R10 ctrl", v, 'h0C);
      rd(A_FLAG, v); check("R10 flags", v, 0);
      rd(A_CNT0, v); check("R10 cnt0", v, 0);
      rd(A_TSEL, v); check("R10 tsel", v, 0);
      rd(A_ACT, v);  check("R10 act0", v, 0);

      // R3 shadow isolation and software transfer
      wr(A_SH, 'h1234);
      rd(A_ACT, v); check("R3 active untouched", v, 0);
      rd(A_SH, v);  check("R3 shadow readback", v, 'h1234);
      wr(A_XFER, 'h01);
      rd(A_ACT, v); check("R3 sw transfer", v, 'h1234);
      rd(A_XFER, v); check("R3 xfer reads zero", v, 0);

      // R5 / R2 duty sweep: ch0 on timer 0 (period 16), ch3 on timer 1 (period 8)
      wr(A_RLD0, P0);
      wr(A_RLD1, P1);
      wr(A_CNT0, P0);
      wr(A_CNT1, P1);
      wr(A_TSEL, 'h38);
      wr(A_CTRL, 'h0F);
      for (int c = 'hFFEC; c <= 'hFFFF; c++) begin
         wr(A_SH, c);
         wr(A_SH + 5'd3, c);
         wr(A_XFER, 'h09);
         idle(40);
         count_hi(0, h0);
         count_hi(3, h3);
         e0 = (c < P0) ? 0 : ('hFFFF - c + 1);
         e3 = (c < P1) ? 0 : 2 * ('hFFFF - c + 1);
         check($sformatf("R5 ch0 duty cmp=%0h", c), h0, e0);
         check($sformatf("R2 ch3 timer1 duty cmp=%0h", c), h3, e3);
      end

      // R6 group polarity
      wr(A_SH, 'hFFFE);
      wr(A_SH + 5'd3, 'hFFFE);
      wr(A_XFER, 'h09);
      wr(A_CTRL, 'h07);
      idle(40);
      count_hi(0, h0); check("R6 group A high", h0, 2);
      count_hi(3, h3); check("R6 group B low-active", h3, 12);
      wr(A_CTRL, 'h03);
      idle(40);
      count_hi(0, h0); check("R6 group A low-active", h0, 14);
      count_hi(1, h0); check("R6 released level is inverse", h0, 16);

      // R9 flags
      wr(A_CTRL, 'h0C);
      idle(4);
      rd(A_FLAG, v); check("R9 flags set", v, 'h09);
      wr(A_FLAG, 'h01);
      rd(A_FLAG, v); check("R9 w1c bit0", v, 'h08);
      wr(A_FLAG, 'h08);
      idle(20);
      rd(A_FLAG, v); check("R9 cleared, stopped timers no match", v, 0);

      // R4 transfer on wrap of selected timer
      wr(A_SH, 'hFFF4);
      rd(A_ACT, v); check("R4 no transfer before wrap", v, 'hFFFE);
      wr(A_CNT0, 'hFFFD);
      wr(A_CTRL, 'h0D);
      idle(6);
      rd(A_ACT, v); check("R4 transfer on wrap", v, 'hFFF4);
      rd(A_ACT + 5'd3, v); check("R2 timer1 channel untouched", v, 'hFFFE);

      // R1 exact counting and wrap (timer 0 running)
      wr(A_CNT0, 'hFFFD);
      rd(A_CNT0, v); check("R1 load", v, 'hFFFD);
      @(negedge clk); rd(A_CNT0, v); check("R1 step", v, 'hFFFE);
      @(negedge clk); rd(A_CNT0, v); check("R1 top", v, 'hFFFF);
      @(negedge clk); rd(A_CNT0, v); check("R1 wrap to reload", v, P0);
      wr(A_CTRL, 'h0C);
      rd(A_CNT0, h0);
      idle(5);
      rd(A_CNT0, v); check("R1 stopped holds", v, h0);

      // R8 forced wrap of timer 1
      wr(A_SH + 5'd3, 'hFFFA);
      wr(A_CNT1, 'h1234);
      wr(A_CTRL, 'h1C);
      rd(A_CNT1, v); check("R8 forced reload", v, P1);
      rd(A_ACT + 5'd3, v); check("R8 forced transfer", v, 'hFFFA);
      rd(A_CTRL, v); check("R8 force bit reads 0", v, 'h0C);
      rd(A_ACT, v); check("R8 timer0 channel unaffected", v, 'hFFF4);
      idle(4);
      rd(A_CNT1, v); check("R8 single forced wrap", v, P1);

      // R7 set mode
      wr(A_MODE, 'h01);
      wr(A_LVL, 'h01);
      wr(A_CNT0, P0);
      wr(A_CTRL, 'h0D);
      idle(40);
      count_hi(0, h0); check("R7 level 1 held over wraps", h0, 16);
      wr(A_LVL, 'h00);
      idle(40);
      count_hi(0, h0); check("R7 level 0 held over wraps", h0, 0);

      finish_run();
   end
endmodule